// File: doc/BRIEF.md
# Stack Sequencer for Subroutine Linkage

This block owns the stack pointer and the program counter of a small byte-addressed processor. It turns single commands into the byte-wide memory cycles that save a 16-bit register pair on a downward-growing stack or restore one from it, and it uses the same stack to link subroutines. A call saves the return address and jumps. A return restores the saved address. Both also come in a form gated by one selected flag.

A push first steps the pointer down and then stores, and it stores the high byte first. A pop first reads and then steps the pointer up, and it reads the low byte first. The pointer therefore always addresses the byte written last. The accumulator-and-flags word is pushed and popped like any other pair: the caller places it on the word input or takes it from the pop output. Instruction fetch and decode stay outside the block. The block only moves the program counter for linkage and for skipped conditional commands.

Memory is a byte array with a combinational read path. The block samples read data at the clock edge that ends a cycle in which it asserts the read strobe. It drives a write in any cycle in which it asserts the write strobe.

Top module: `stack_seq`

## Requirements
- R1: After reset the pointer is FFFFh, the program counter is 0000h, busy is low and neither memory strobe is asserted.
- R2: Command code 1 (load pointer) copies the command word into the pointer at the accepting edge. It makes no memory access and leaves the program counter unchanged.
- R3: Command code 2 (push) makes two write cycles. The first writes the word's high byte to pointer-1. The second writes the low byte to pointer-2. The pointer ends at its old value minus 2.
- R4: Command code 3 (pop) makes two read cycles, at the pointer and then at pointer+1. The bytes read are the low and the high half of the result. The pointer ends at its old value plus 2. The result appears on the pop output with its valid strobe high for exactly one cycle, in the cycle after the second read.
- R5: Command code 4 (call) pushes the program counter plus 3, high byte first, with the same addressing as a push. It then loads the program counter with the command word.
- R6: Command code 5 (return) pops two bytes with the same addressing as a pop and loads them into the program counter. The pop output strobe stays low.
- R7: Command codes 6 (conditional call) and 7 (conditional return) evaluate a 3-bit condition. Bits 2:1 select a flag: 0 zero, 1 carry, 2 parity, 3 sign. These flags are flag input bits 0, 1, 2 and 3. Bit 0 gives the required flag value. When the selected flag equals bit 0, the command behaves exactly like code 4 or code 5.
- R8: When the condition fails, the conditional call adds 3 to the program counter and the conditional return adds 1. Neither makes a memory access, and the pointer stays unchanged.
- R9: Busy is high from the cycle after a stack access command is accepted until its second memory cycle, and for exactly those two cycles. Commands presented while busy is high are ignored. Write and read strobes are never high together.
- R10: Pointer and program counter arithmetic wraps modulo 2^16.
- R11: Command code 0 changes no state and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0..7) |
| cmd_cond | input | 3 | Flag select (bits 2:1) and required value (bit 0) |
| flags | input | 4 | Zero, carry, parity, sign at bits 0..3 |
| cmd_word | input | 16 | Pair to push, new pointer, or call target |
| busy | output | 1 | Memory sequence in progress |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read at mem_addr |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pop_word | output | 16 | Pair restored by a pop |
| pop_valid | output | 1 | One-cycle strobe for pop_word |

## Verification
The assertions assume that the memory returns the addressed byte combinationally during a read cycle. They also assume that the flags and the condition are stable in the cycle a command is accepted. The bench models memory as a combinational array and drives every command input at the falling edge, so both assumptions hold. Commands that are meant to be accepted are issued only when busy is low. The one command deliberately presented during busy is there to show that it is ignored. The sweep of all eight conditions against all sixteen flag patterns therefore reaches both the taken and the skipped paths with consistent inputs.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_LDSP  = 3'd1,
      OP_PUSH  = 3'd2,
      OP_POP   = 3'd3,
      OP_CALL  = 3'd4,
      OP_RET   = 3'd5,
      OP_CCALL = 3'd6,
      OP_CRET  = 3'd7
   } stk_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_HI,
      ST_WR_LO,
      ST_RD_LO,
      ST_RD_HI
   } stk_state_e;

   typedef enum logic [1:0] {
      PTR_HOLD,
      PTR_LOAD,
      PTR_DEC,
      PTR_INC
   } ptr_cmd_e;

endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval #(
   parameter int  NUM_FLAGS = 4,
   localparam int SEL_W     = $clog2(NUM_FLAGS),
   localparam int COND_W    = SEL_W + 1
) (
   input  logic [NUM_FLAGS-1:0] flags_i,
   input  logic [COND_W-1:0]    cond_i,
   output logic                 pass_o
);

   generate
      if (NUM_FLAGS < 2 || (NUM_FLAGS & (NUM_FLAGS - 1)) != 0) begin : g_bad_flags
         $error("stk_cond_eval: NUM_FLAGS must be a power of two of at least 2");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] match;

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         assign match[g] = (flags_i[g] == cond_i[0]);
      end
   endgenerate

   always_comb begin
      pass_o = 1'b0;
      for (int i = 0; i < NUM_FLAGS; i++) begin
         if (cond_i[COND_W-1:1] == SEL_W'(i)) begin
            pass_o = match[i];
         end
      end
   end

endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
   import stk_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_SP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ptr_cmd_e          cmd_i,
   input  logic [ADDR_W-1:0] load_i,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] sp_dec_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_o <= RESET_SP;
      end else begin
         unique case (cmd_i)
            PTR_LOAD: sp_o <= load_i;
            PTR_DEC:  sp_o <= sp_o - STEP;
            PTR_INC:  sp_o <= sp_o + STEP;
            default:  sp_o <= sp_o;
         endcase
      end
   end

   assign sp_dec_o = sp_o - STEP;

   assert_wrap_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == PTR_DEC && sp_o == '0) |=> sp_o == '1);

   assert_wrap_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == PTR_INC && sp_o == '1) |=> sp_o == '0);

endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
   import stk_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                BYTE_W   = 8,
   parameter int                CALL_LEN = 3,
   parameter int                RET_LEN  = 1,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   localparam int               WORD_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  stk_op_e           op_i,
   input  logic              cond_pass_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [ADDR_W-1:0] sp_i,
   input  logic [ADDR_W-1:0] sp_dec_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output ptr_cmd_e          ptr_cmd_o,
   output logic              busy_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              we_o,
   output logic              re_o,
   output logic [WORD_W-1:0] pop_word_o,
   output logic              pop_valid_o
);

   localparam logic [ADDR_W-1:0] CALL_STEP = ADDR_W'(CALL_LEN);
   localparam logic [ADDR_W-1:0] RET_STEP  = ADDR_W'(RET_LEN);

   stk_state_e        state_q, state_d;
   logic [WORD_W-1:0] data_q;
   logic [BYTE_W-1:0] lo_q;
   logic [ADDR_W-1:0] target_q;
   logic              redirect_q;

   logic              accept;
   logic              start_push, start_pop, linkage, load_sp, skip;
   logic [ADDR_W-1:0] skip_step;

   assign accept = cmd_valid_i && (state_q == ST_IDLE);
   assign busy_o = (state_q != ST_IDLE);

   // command decode in the idle state
   always_comb begin
      start_push = 1'b0;
      start_pop  = 1'b0;
      linkage    = 1'b0;
      load_sp    = 1'b0;
      skip       = 1'b0;
      skip_step  = '0;
      if (accept) begin
         case (op_i)
            OP_LDSP: load_sp = 1'b1;
            OP_PUSH: start_push = 1'b1;
            OP_POP:  start_pop = 1'b1;
            OP_CALL: begin
               start_push = 1'b1;
               linkage    = 1'b1;
            end
            OP_RET: begin
               start_pop = 1'b1;
               linkage   = 1'b1;
            end
            OP_CCALL: begin
               if (cond_pass_i) begin
                  start_push = 1'b1;
                  linkage    = 1'b1;
               end else begin
                  skip      = 1'b1;
                  skip_step = CALL_STEP;
               end
            end
            OP_CRET: begin
               if (cond_pass_i) begin
                  start_pop = 1'b1;
                  linkage   = 1'b1;
               end else begin
                  skip      = 1'b1;
                  skip_step = RET_STEP;
               end
            end
            default: ;
         endcase
      end
   end

   // next state and pointer control
   always_comb begin
      state_d   = state_q;
      ptr_cmd_o = PTR_HOLD;
      unique case (state_q)
         ST_IDLE: begin
            if (start_push)     state_d = ST_WR_HI;
            else if (start_pop) state_d = ST_RD_LO;
            if (load_sp)        ptr_cmd_o = PTR_LOAD;
         end
         ST_WR_HI: begin
            state_d   = ST_WR_LO;
            ptr_cmd_o = PTR_DEC;
         end
         ST_WR_LO: begin
            state_d   = ST_IDLE;
            ptr_cmd_o = PTR_DEC;
         end
         ST_RD_LO: begin
            state_d   = ST_RD_HI;
            ptr_cmd_o = PTR_INC;
         end
         ST_RD_HI: begin
            state_d   = ST_IDLE;
            ptr_cmd_o = PTR_INC;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // memory side: writes go one below the pointer, reads at the pointer
   always_comb begin
      mem_addr_o = sp_i;
      wdata_o    = '0;
      we_o       = 1'b0;
      re_o       = 1'b0;
      unique case (state_q)
         ST_WR_HI: begin
            mem_addr_o = sp_dec_i;
            wdata_o    = data_q[WORD_W-1:BYTE_W];
            we_o       = 1'b1;
         end
         ST_WR_LO: begin
            mem_addr_o = sp_dec_i;
            wdata_o    = data_q[BYTE_W-1:0];
            we_o       = 1'b1;
         end
         ST_RD_LO, ST_RD_HI: begin
            re_o = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pc_o        <= RESET_PC;
         data_q      <= '0;
         lo_q        <= '0;
         target_q    <= '0;
         redirect_q  <= 1'b0;
         pop_word_o  <= '0;
         pop_valid_o <= 1'b0;
      end else begin
         state_q     <= state_d;
         pop_valid_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_push) begin
                  data_q     <= linkage ? (pc_o + CALL_STEP) : word_i;
                  target_q   <= word_i;
                  redirect_q <= linkage;
               end
               if (start_pop) begin
                  redirect_q <= linkage;
               end
               if (skip) begin
                  pc_o <= pc_o + skip_step;
               end
            end
            ST_WR_LO: begin
               if (redirect_q) pc_o <= target_q;
            end
            ST_RD_LO: begin
               lo_q <= rdata_i;
            end
            ST_RD_HI: begin
               if (redirect_q) begin
                  pc_o <= {rdata_i, lo_q};
               end else begin
                  pop_word_o  <= {rdata_i, lo_q};
                  pop_valid_o <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_o && re_o));

   assert_busy_two_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> busy_o);

   assert_low_byte_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_LO) |-> mem_addr_o == $past(mem_addr_o) - ADDR_W'(1));

   assert_high_byte_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD_HI) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

   assert_pop_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid_o |-> $past(state_q == ST_RD_HI && !redirect_q));

   assert_skip_keeps_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && skip) |=> (!busy_o && $stable(sp_i)));

   assert_load_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_i == OP_LDSP) |=> sp_i == $past(word_i));

   assert_call_jumps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_LO && redirect_q) |=> pc_o == $past(target_q));

endmodule

// File: rtl/stack_seq.sv
module stack_seq
   import stk_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                BYTE_W    = 8,
   parameter int                NUM_FLAGS = 4,
   parameter int                CALL_LEN  = 3,
   parameter int                RET_LEN   = 1,
   parameter logic [ADDR_W-1:0] RESET_PC  = '0,
   parameter logic [ADDR_W-1:0] RESET_SP  = '1,
   localparam int               WORD_W    = 2 * BYTE_W,
   localparam int               COND_W    = $clog2(NUM_FLAGS) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [COND_W-1:0]    cmd_cond,
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [WORD_W-1:0]    cmd_word,
   output logic                 busy,
   output logic [ADDR_W-1:0]    pc,
   output logic [ADDR_W-1:0]    sp,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [BYTE_W-1:0]    mem_wdata,
   input  logic [BYTE_W-1:0]    mem_rdata,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [WORD_W-1:0]    pop_word,
   output logic                 pop_valid
);

   generate
      if (ADDR_W != WORD_W) begin : g_bad_width
         $error("stack_seq: a saved pair must be exactly one address wide");
      end
      if (CALL_LEN < 1 || RET_LEN < 1) begin : g_bad_len
         $error("stack_seq: instruction lengths must be positive");
      end
   endgenerate

   stk_op_e           op_e;
   logic              cond_pass;
   ptr_cmd_e          ptr_cmd;
   logic [ADDR_W-1:0] sp_dec;

   assign op_e = stk_op_e'(cmd_op);

   stk_cond_eval #(
      .NUM_FLAGS (NUM_FLAGS)
   ) cond_i (
      .flags_i (flags),
      .cond_i  (cmd_cond),
      .pass_o  (cond_pass)
   );

   stk_ptr_unit #(
      .ADDR_W   (ADDR_W),
      .RESET_SP (RESET_SP)
   ) ptr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (ptr_cmd),
      .load_i   (cmd_word),
      .sp_o     (sp),
      .sp_dec_o (sp_dec)
   );

   stk_seq_fsm #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .CALL_LEN (CALL_LEN),
      .RET_LEN  (RET_LEN),
      .RESET_PC (RESET_PC)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .op_i        (op_e),
      .cond_pass_i (cond_pass),
      .word_i      (cmd_word),
      .sp_i        (sp),
      .sp_dec_i    (sp_dec),
      .rdata_i     (mem_rdata),
      .ptr_cmd_o   (ptr_cmd),
      .busy_o      (busy),
      .pc_o        (pc),
      .mem_addr_o  (mem_addr),
      .wdata_o     (mem_wdata),
      .we_o        (mem_we),
      .re_o        (mem_re),
      .pop_word_o  (pop_word),
      .pop_valid_o (pop_valid)
   );

   assert_quiet_while_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> (!mem_we && !mem_re));

endmodule

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [2:0]  cmd_cond = '0;
   logic [3:0]  flags = '0;
   logic [15:0] cmd_word = '0;
   logic        busy;
   logic [15:0] pc, sp, mem_addr, pop_word;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_we, mem_re, pop_valid;

   always #2.5 clk = ~clk;

   stack_seq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_cond  (cmd_cond),
      .flags     (flags),
      .cmd_word  (cmd_word),
      .busy      (busy),
      .pc        (pc),
      .sp        (sp),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .pop_word  (pop_word),
      .pop_valid (pop_valid)
   );

   // memory seen by the design (low 8 address bits) and the bench's own model
   logic [7:0] bmem [0:255];
   logic [7:0] mdl  [0:255];
   assign mem_rdata = bmem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // observed accesses
   int          wr_n, rd_n;
   logic [15:0] wa [0:3];
   logic [7:0]  wd [0:3];
   logic [15:0] ra [0:3];
   bit          pop_seen;
   logic [15:0] pop_w;

   always @(negedge clk) begin
      if (mem_we) begin
         if (wr_n < 4) begin
            wa[wr_n] = mem_addr;
            wd[wr_n] = mem_wdata;
         end
         wr_n++;
      end
      if (mem_re) begin
         if (rd_n < 4) ra[rd_n] = mem_addr;
         rd_n++;
      end
      if (pop_valid) begin
         pop_seen = 1'b1;
         pop_w    = pop_word;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R9 watchdog actual=%0d expected=<150000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   logic [15:0] m_sp, m_pc;

   task automatic exec(input logic [2:0] op, input logic [2:0] cc, input logic [3:0] fl,
                       input logic [15:0] w, input bit inject, input string tag);
      logic [15:0] e_sp, e_pc, e_pop, pv, a0, a1;
      logic [15:0] e_wa [0:1];
      logic [7:0]  e_wd [0:1];
      logic [15:0] e_ra [0:1];
      int          e_wn, e_rn, bc;
      bit          tk, do_push, do_pop, link, e_popv;
      tk = (fl[cc[2:1]] == cc[0]);
      e_sp = m_sp; e_pc = m_pc; e_wn = 0; e_rn = 0; e_popv = 1'b0; e_pop = '0;
      do_push = 1'b0; do_pop = 1'b0; link = 1'b0; pv = w;
      case (op)
         3'd1: e_sp = w;
         3'd2: do_push = 1'b1;
         3'd3: do_pop = 1'b1;
         3'd4: begin do_push = 1'b1; link = 1'b1; end
         3'd5: begin do_pop = 1'b1; link = 1'b1; end
         3'd6: if (tk) begin do_push = 1'b1; link = 1'b1; end else e_pc = m_pc + 16'd3;
         3'd7: if (tk) begin do_pop = 1'b1; link = 1'b1; end else e_pc = m_pc + 16'd1;
         default: ;
      endcase
      if (do_push) begin
         if (link) begin pv = m_pc + 16'd3; e_pc = w; end
         a0 = m_sp - 16'd1; a1 = m_sp - 16'd2;
         e_wa[0] = a0; e_wd[0] = pv[15:8];
         e_wa[1] = a1; e_wd[1] = pv[7:0];
         e_wn = 2; e_sp = a1;
         mdl[a0[7:0]] = pv[15:8];
         mdl[a1[7:0]] = pv[7:0];
      end
      if (do_pop) begin
         a0 = m_sp; a1 = m_sp + 16'd1;
         e_ra[0] = a0; e_ra[1] = a1; e_rn = 2;
         e_pop = {mdl[a1[7:0]], mdl[a0[7:0]]};
         e_sp = m_sp + 16'd2;
         if (link) e_pc = e_pop; else e_popv = 1'b1;
      end

      @(negedge clk);
      wr_n = 0; rd_n = 0; pop_seen = 1'b0;
      cmd_valid = 1'b1; cmd_op = op; cmd_cond = cc; flags = fl; cmd_word = w;
      @(negedge clk);
      if (inject) begin
         cmd_op = 3'd1; cmd_word = 16'h1234;
      end else begin
         cmd_valid = 1'b0;
      end
      bc = 0;
      while (busy && bc < 50) begin
         bc++;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      cmd_valid = 1'b0;
      #1;
      chk({tag, " pointer"}, 32'(sp), 32'(e_sp));
      chk({tag, " program counter"}, 32'(pc), 32'(e_pc));
      chk("R9 busy cycles", 32'(bc), (do_push || do_pop) ? 32'd2 : 32'd0);
      chk({tag, " write count"}, 32'(wr_n), 32'(e_wn));
      chk({tag, " read count"}, 32'(rd_n), 32'(e_rn));
      for (int i = 0; i < e_wn && i < wr_n; i++) begin
         chk({tag, " write address"}, 32'(wa[i]), 32'(e_wa[i]));
         chk({tag, " write data"}, 32'(wd[i]), 32'(e_wd[i]));
      end
      for (int i = 0; i < e_rn && i < rd_n; i++) begin
         chk({tag, " read address"}, 32'(ra[i]), 32'(e_ra[i]));
      end
      chk({tag, " pop strobe"}, 32'(pop_seen), 32'(e_popv));
      if (e_popv && pop_seen) chk({tag, " pop word"}, 32'(pop_w), 32'(e_pop));
      m_sp = e_sp;
      m_pc = e_pc;
   endtask

   initial begin
      logic [15:0] v;
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 8'(i * 7 + 3);
         mdl[i]  = 8'(i * 7 + 3);
      end
      wr_n = 0; rd_n = 0; pop_seen = 1'b0; pop_w = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 pointer", 32'(sp), 32'hFFFF);
      chk("R1 program counter", 32'(pc), 32'h0000);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 strobes", {30'd0, mem_we, mem_re}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_sp = 16'hFFFF; m_pc = 16'h0000;

      // R11 idle command
      exec(3'd0, 3'd0, 4'h0, 16'hDEAD, 1'b0, "R11");
      // R2 load pointer
      exec(3'd1, 3'd0, 4'h0, 16'h0080, 1'b0, "R2");
      // R3 / R4 push a series, then pop it back
      for (int i = 0; i < 8; i++) begin
         v = 16'(i * 16'h1111) ^ 16'h8001;
         exec(3'd2, 3'd0, 4'h0, v, 1'b0, "R3");
      end
      for (int i = 0; i < 8; i++) begin
         exec(3'd3, 3'd0, 4'h0, 16'h0000, 1'b0, "R4");
      end
      // R9 command during busy is ignored
      exec(3'd2, 3'd0, 4'h0, 16'hA5C3, 1'b1, "R9");
      exec(3'd3, 3'd0, 4'h0, 16'h0000, 1'b0, "R4");
      // R10 pointer wrap across address zero
      exec(3'd1, 3'd0, 4'h0, 16'h0001, 1'b0, "R10");
      exec(3'd2, 3'd0, 4'h0, 16'hBEEF, 1'b0, "R10");
      exec(3'd3, 3'd0, 4'h0, 16'h0000, 1'b0, "R10");
      exec(3'd1, 3'd0, 4'h0, 16'h0000, 1'b0, "R10");
      exec(3'd3, 3'd0, 4'h0, 16'h0000, 1'b0, "R10");
      // R5 / R6 nested calls and returns
      exec(3'd1, 3'd0, 4'h0, 16'h0040, 1'b0, "R2");
      exec(3'd4, 3'd0, 4'h0, 16'h2085, 1'b0, "R5");
      exec(3'd4, 3'd0, 4'h0, 16'h3000, 1'b0, "R5");
      exec(3'd5, 3'd0, 4'h0, 16'h0000, 1'b0, "R6");
      exec(3'd5, 3'd0, 4'h0, 16'h0000, 1'b0, "R6");
      // R7 / R8 every condition against every flag pattern
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 16; f++) begin
            logic [3:0] fl4;
            logic [2:0] cc3;
            fl4 = 4'(f);
            cc3 = 3'(c);
            exec(3'd6, cc3, fl4, 16'(16'h4000 + c * 16 + f), 1'b0,
                 (fl4[cc3[2:1]] == cc3[0]) ? "R7" : "R8");
            exec(3'd7, cc3, fl4, 16'h0000, 1'b0,
                 (fl4[cc3[2:1]] == cc3[0]) ? "R7" : "R8");
         end
      end
      // R10 program counter wrap on a skipped conditional call
      exec(3'd4, 3'd0, 4'h0, 16'hFFFE, 1'b0, "R5");
      exec(3'd6, 3'd3, 4'h0, 16'h1111, 1'b0, "R10");
      exec(3'd7, 3'd3, 4'h0, 16'h0000, 1'b0, "R10");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule